// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit

This block is a parameterised integer adder/subtractor that produces a combinational result and keeps a four-bit condition-flag register. A two-bit opcode picks plain addition, addition with carry-in, subtraction, or subtraction with carry-in. A swap input exchanges the two operands before the operation, which gives the reverse forms of subtraction with no extra datapath. The carry-in of the carry-using forms comes from the carry bit held in the flag register.

When the flag-write input is high at a rising clock edge, the negative, zero, carry and overflow flags computed from the current operation are loaded together. When it is low, the register keeps its value. For subtraction the carry flag means "no borrow".

Top module: `flagged_addsub`

## Requirements
- R1: With op_sel = 2'b00 the result is A + B modulo 2^WIDTH; with op_sel = 2'b01 it is A + B + C, where C is the stored carry flag (flags_q[1]).
- R2: For op_sel 2'b00 the carry written is 1 when the result is unsigned-less than A; for 2'b01 it is 1 when the result is unsigned-less than A (stored C = 0), or less than or equal to A (stored C = 1).
- R3: With op_sel = 2'b10 the result is A - B and the carry written is 1 when A >= B unsigned; with op_sel = 2'b11 the result is A - B - 1 with carry (A > B) when stored C = 0, and A - B with carry (A >= B) when stored C = 1.
- R4: The overflow flag (flags_q[0]) is written as the top bit of (A XNOR B) AND (A XOR result) for additions, and of (A XOR B) AND (A XOR result) for subtractions.
- R5: The negative flag (flags_q[3]) is written as the top result bit and the zero flag (flags_q[2]) as 1 exactly when the result is all zeros.
- R6: When swap_ops is 1, A is taken from opnd_b and B from opnd_a for every opcode, results and flags included.
- R7: All four flags load on a rising clock edge when flag_we is 1; when flag_we is 0 they keep their value and the result is still produced.
- R8: An active-low reset clears flags_q to 4'b0000.
- R9: The carry-in of op_sel 2'b01 and 2'b11 is the carry flag as stored before the edge, so a chain of such operations propagates carry across words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with carry |
| swap_ops | input | 1 | Exchange operands before the operation |
| flag_we | input | 1 | Load the flag register at this edge |
| result | output | WIDTH | Combinational operation result |
| flags_q | output | 4 | Stored flags {N, Z, C, V} |

## Verification
A wrong stored carry is visible at the result port in the very next cycle that issues a carry-using opcode, because that bit feeds the adder directly; the bench chains carry-using operations so such a fault shows within one operation. Wrong N, Z or V bits appear on flags_q one edge after the write that produced them, and a flag register that loads while flag_we is low shows up one cycle later against the held value. Random operands are mixed with wrap, equality and sign-boundary cases where the carry and overflow rules differ between addition and subtraction.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_ADC = 2'b01,
      OP_SUB = 2'b10,
      OP_SBC = 2'b11
   } addsub_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   localparam int unsigned NZCV_W = 4;

endpackage

// File: rtl/addsub_opnd_prep.sv
module addsub_opnd_prep
   import addsub_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   input  logic [1:0]       op_sel,
   input  logic             swap_ops,
   input  logic             carry_st,
   output logic [WIDTH-1:0] eff_a,
   output logic [WIDTH-1:0] eff_b,
   output logic             cin,
   output logic             is_sub
);

   logic [WIDTH-1:0] pick_a;
   logic [WIDTH-1:0] pick_b;

   always_comb begin
      pick_a = swap_ops ? in_b : in_a;
      pick_b = swap_ops ? in_a : in_b;
      is_sub = op_sel[1];
      eff_a  = pick_a;
      eff_b  = is_sub ? ~pick_b : pick_b;
      unique case (addsub_op_e'(op_sel))
         OP_ADD:  cin = 1'b0;
         OP_ADC:  cin = carry_st;
         OP_SUB:  cin = 1'b1;
         OP_SBC:  cin = carry_st;
         default: cin = 1'b0;
      endcase
   end

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
   parameter int unsigned WIDTH  = 32,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = x[i] ^ y[i] ^ chain[i];
            assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
         end
         assign cout = chain[WIDTH];
      end else begin : g_flat
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
   import addsub_pkg::*;
#(
   parameter logic [NZCV_W-1:0] RESET_VAL = '0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  nzcv_t next_flags,
   output nzcv_t flags
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= nzcv_t'(RESET_VAL);
      end else if (load) begin
         flags <= next_flags;
      end
   end

endmodule

// File: rtl/flagged_addsub.sv
module flagged_addsub
   import addsub_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [1:0]       op_sel,
   input  logic             swap_ops,
   input  logic             flag_we,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       flags_q
);

   localparam int unsigned MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("flagged_addsub: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] eff_a;
   logic [WIDTH-1:0] eff_b;
   logic             cin;
   logic             is_sub;
   logic [WIDTH-1:0] sum;
   logic             cout;
   nzcv_t            cur;
   nzcv_t            nxt;

   addsub_opnd_prep #(.WIDTH(WIDTH)) u_prep (
      .in_a     (opnd_a),
      .in_b     (opnd_b),
      .op_sel   (op_sel),
      .swap_ops (swap_ops),
      .carry_st (cur.c),
      .eff_a    (eff_a),
      .eff_b    (eff_b),
      .cin      (cin),
      .is_sub   (is_sub)
   );

   addsub_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .x    (eff_a),
      .y    (eff_b),
      .cin  (cin),
      .sum  (sum),
      .cout (cout)
   );

   // eff_b already carries the inversion for subtraction, so one
   // same-sign-in / different-sign-out test covers both directions.
   always_comb begin
      nxt.n = sum[MSB];
      nxt.z = (sum == '0);
      nxt.c = cout;
      nxt.v = (eff_a[MSB] == eff_b[MSB]) && (sum[MSB] != eff_a[MSB]);
   end

   addsub_flag_reg #(.RESET_VAL('0)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (flag_we),
      .next_flags (nxt),
      .flags      (cur)
   );

   assign result  = sum;
   assign flags_q = cur;

endmodule

// File: rtl/flagged_addsub_chk.sv
module flagged_addsub_chk #(
   parameter int unsigned WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [1:0]       op_sel,
   input logic             swap_ops,
   input logic             flag_we,
   input logic [WIDTH-1:0] result,
   input logic [3:0]       flags_q
);

   // R7
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |=> $stable(flags_q));

   // R5
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (flags_q[2] == ($past(result) == '0)));

   // R5
   neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (flags_q[3] == $past(result[WIDTH-1])));

   // R3
   sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 2'b10 && !swap_ops) |=> (flags_q[1] == ($past(opnd_a) >= $past(opnd_b))));

   // R1
   add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b00 && !swap_ops) |-> (result == opnd_a + opnd_b));

   // R6
   swap_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b10 && swap_ops) |-> (result == opnd_b - opnd_a));

   // R8
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_flags_chk: assert (flags_q == 4'b0000);
      end
   end

endmodule

bind flagged_addsub flagged_addsub_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .opnd_a   (opnd_a),
   .opnd_b   (opnd_b),
   .op_sel   (op_sel),
   .swap_ops (swap_ops),
   .flag_we  (flag_we),
   .result   (result),
   .flags_q  (flags_q)
);

// File: tb/sim_flagged_addsub.sv
`timescale 1ns/1ps
module sim_flagged_addsub;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  opnd_a = '0;
   logic [W-1:0]  opnd_b = '0;
   logic [1:0]    op_sel = '0;
   logic          swap_ops = 1'b0;
   logic          flag_we = 1'b0;
   logic [W-1:0]  result;
   logic [3:0]    flags_q;

   int errors = 0;
   int checks = 0;
   logic [3:0] mdl_flags = 4'b0000;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   flagged_addsub #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .op_sel(op_sel), .swap_ops(swap_ops), .flag_we(flag_we),
      .result(result), .flags_q(flags_q)
   );

   function automatic logic [W+3:0] ref_op(input logic [W-1:0] a0, input logic [W-1:0] b0,
                                           input logic [1:0] op, input logic sw, input logic c_st);
      logic [W-1:0] a, b, r;
      logic c, v, n, z;
      a = sw ? b0 : a0;
      b = sw ? a0 : b0;
      case (op)
         2'b00: begin r = a + b; c = (r < a); end
         2'b01: begin
            if (c_st) begin r = a + b + 1; c = (r <= a); end
            else      begin r = a + b;     c = (r < a);  end
         end
         2'b10: begin r = a - b; c = (a >= b); end
         default: begin
            if (c_st) begin r = a - b;     c = (a >= b); end
            else      begin r = a - b - 1; c = (a > b);  end
         end
      endcase
      if (op[1]) v = ((a ^ b) & (a ^ r)) >> (W-1);
      else       v = ((~(a ^ b)) & (a ^ r)) >> (W-1);
      n = r[W-1];
      z = (r == '0);
      return {r, n, z, c, v};
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [1:0] op, input logic sw, input logic we);
      logic [W+3:0] e;
      @(negedge clk);
      opnd_a = a; opnd_b = b; op_sel = op; swap_ops = sw; flag_we = we;
      #1;
      e = ref_op(a, b, op, sw, mdl_flags[1]);
      if (sw)          check("R6 result", result, e[W+3:4]);
      else if (op[1])  check("R3 R9 result", result, e[W+3:4]);
      else             check("R1 R9 result", result, e[W+3:4]);
      if (we) mdl_flags = e[3:0];
      @(posedge clk);
      #1;
      if (we) check("R2 R3 R4 R5 flags", {28'd0, flags_q}, {28'd0, mdl_flags});
      else    check("R7 hold", {28'd0, flags_q}, {28'd0, mdl_flags});
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #1;
      check("R8 reset", {28'd0, flags_q}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R7: operation without write leaves flags cleared
      step(32'hFFFF_FFFF, 32'h1, 2'b00, 1'b0, 1'b0);
      // R2 R5: wrap to zero with carry
      step(32'hFFFF_FFFF, 32'h1, 2'b00, 1'b0, 1'b1);
      // R4: signed overflow on add
      step(32'h7FFF_FFFF, 32'h1, 2'b00, 1'b0, 1'b1);
      // R3: equal subtract, carry set, zero set
      step(32'h1234, 32'h1234, 2'b10, 1'b0, 1'b1);
      // R9: carry=1 stored, adc a+b+1 equal to a keeps carry
      step(32'h5, 32'hFFFF_FFFF, 2'b01, 1'b0, 1'b1);
      // R3: borrow, carry clear, negative
      step(32'h0, 32'h1, 2'b10, 1'b0, 1'b1);
      // R9: sbc with stored carry 0 on equal operands gives -1
      step(32'h77, 32'h77, 2'b11, 1'b0, 1'b1);
      // R4: subtract overflow
      step(32'h8000_0000, 32'h1, 2'b10, 1'b0, 1'b1);
      // R6: reverse subtract
      step(32'h10, 32'h3, 2'b10, 1'b1, 1'b1);
      // R7: hold after nonzero flags
      step(32'h0, 32'h0, 2'b00, 1'b0, 1'b0);
      // R9: 64-bit chained add across two words
      step(32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 1'b0, 1'b1);
      step(32'h0000_0001, 32'h0000_0002, 2'b01, 1'b0, 1'b1);

      for (int i = 0; i < 600; i++) begin
         logic [W-1:0] ra, rb;
         ra = $urandom();
         rb = ($urandom() % 8 == 0) ? ra : $urandom();
         step(ra, rb, 2'($urandom()), 1'($urandom()), ($urandom() % 4) != 0);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule